// File: doc/BRIEF.md
# ADC Capture and Power-Down Sequencer

This block sits between an 8-bit pipelined sampling converter and the logic that uses its samples. It runs on the converter's encode clock and registers one raw parallel word on every rising edge. It drives the converter's active-high power-down line. A word reaches the output stream only when the converter is awake, has settled and has refilled its four-stage pipeline. Words taken while the converter is entering sleep or is asleep carry no meaning, because its data lines float then, and they are discarded.

Accepted words are changed from offset binary to two's complement by inverting the most significant bit. Each one is presented on a valid/ready output together with a saturation flag. The converter cannot be stalled. A sample that meets a low ready is therefore lost, and a sticky overflow flag records the loss until the host clears it. The host controls sleep and wake with single-cycle request pulses.

Top module: `adc_capture_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block drives `pwrDown`, `outValid` and `ovfFlag` low after that edge.
- R2: After the last reset edge, `outValid` stays low for the next 19 edges, which are 15 settling cycles plus 4 pipeline-fill cycles. The first valid sample appears after the 20th edge.
- R3: While the block is active, each edge captures `rawCode`. After that same edge, `outValid` is high and `outSample` equals `rawCode` with its MSB inverted. Examples: 0x00 gives 0x80, 0xFF gives 0x7F, 0x80 gives 0x00 and 0x7F gives 0xFF.
- R4: `outSat` is high together with a valid sample exactly when the raw code was 0x00 or 0xFF.
- R5: A `sleepReq` pulse seen at an edge while the converter is awake drives `pwrDown` high and `outValid` low after that same edge.
- R6: `pwrDown` stays high through the 2-cycle entry window and the whole sleep period. `outValid` stays low during that time, whatever `rawCode` carries.
- R7: A `wakeReq` pulse seen while asleep drives `pwrDown` low after that edge. `outValid` stays low for the next 19 edges and goes high after the 20th.
- R8: `wakeReq` has no effect unless the block is asleep, including during the entry window. `sleepReq` has no effect while entering sleep or asleep.
- R9: If `outValid` is high and `outReady` is low at an edge, `ovfFlag` is set after that edge. It holds until `ovfClear` is high at an edge. If a new loss happens at the same edge as a clear, the flag stays set.
- R10: A `sleepReq` during the settling or fill interval aborts it and starts sleep entry. `pwrDown` goes high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; converter samples and block registers on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleepReq | input | 1 | Host sleep request pulse |
| wakeReq | input | 1 | Host wake request pulse |
| rawCode | input | 8 | Offset-binary word from the converter |
| pwrDown | output | 1 | Active-high power-down drive to the converter |
| outReady | input | 1 | Downstream ready |
| outValid | output | 1 | Sample valid |
| outSample | output | 8 | Two's-complement sample |
| outSat | output | 1 | Sample came from code 0x00 or 0xFF |
| ovfFlag | output | 1 | Sticky lost-sample flag |
| ovfClear | input | 1 | Clears `ovfFlag` |

## Verification
The conversion is driven with a table of codes. The table holds both rail values, which must raise saturation, and the two codes either side of mid-scale, which tell MSB inversion apart from sign extension or full inversion. It also holds alternating-bit and near-rail words, which show that only the MSB flips. The sequencing is tried from reset, from a normal sleep and wake, and from a sleep that cuts a settling interval short. Counting edges to the first valid sample separates the settle count from the fill count. Wake pulses during the active and entry states show whether request gating is state dependent. Lost-sample cases with and without a clear at the same edge separate set priority from clear priority.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_ACTIVE = 3'd0,
    SEQ_ENTER  = 3'd1,
    SEQ_ASLEEP = 3'd2,
    SEQ_SETTLE = 3'd3,
    SEQ_FILL   = 3'd4
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic flush;
  } seq_ctrl_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 15,
  parameter int PIPE_LAT   = 4,
  parameter int ENTER_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleepReq,
  input  logic       wakeReq,
  output logic       pwrDown,
  output seq_ctrl_t  ctrl,
  output seq_state_e seqState
);

  localparam int MAX_A   = (SETTLE_CYC > PIPE_LAT) ? SETTLE_CYC : PIPE_LAT;
  localparam int MAX_CYC = (MAX_A > ENTER_CYC) ? MAX_A : ENTER_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] FILL_LD   = CNT_W'(PIPE_LAT - 1);
  localparam logic [CNT_W-1:0] ENTER_LD  = CNT_W'(ENTER_CYC - 1);

  seq_state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic awake;
  logic cntDone;

  assign awake   = (stateQ == SEQ_ACTIVE) || (stateQ == SEQ_SETTLE) || (stateQ == SEQ_FILL);
  assign cntDone = (cntQ == '0);

  always_comb begin
    stateD = stateQ;
    cntD   = cntDone ? cntQ : cntQ - 1'b1;
    if (awake && sleepReq) begin
      stateD = SEQ_ENTER;
      cntD   = ENTER_LD;
    end else begin
      unique case (stateQ)
        SEQ_ACTIVE: cntD = '0;
        SEQ_ENTER: begin
          if (cntDone) stateD = SEQ_ASLEEP;
        end
        SEQ_ASLEEP: begin
          cntD = '0;
          if (wakeReq) begin
            stateD = SEQ_SETTLE;
            cntD   = SETTLE_LD;
          end
        end
        SEQ_SETTLE: begin
          if (cntDone) begin
            stateD = SEQ_FILL;
            cntD   = FILL_LD;
          end
        end
        SEQ_FILL: begin
          if (cntDone) stateD = SEQ_ACTIVE;
        end
        default: begin
          stateD = SEQ_SETTLE;
          cntD   = SETTLE_LD;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= SEQ_SETTLE;
      cntQ    <= SETTLE_LD;
      pwrDown <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      pwrDown <= (stateD == SEQ_ENTER) || (stateD == SEQ_ASLEEP);
    end
  end

  // a word is taken only in the active state and never on the edge sleep is requested
  assign ctrl.accept = (stateQ == SEQ_ACTIVE) && !sleepReq;
  assign ctrl.flush  = rst;
  assign seqState    = stateQ;

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  seq_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] rawCode,
  input  logic              outReady,
  input  logic              ovfClear,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample,
  output logic              outSat
);

  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CODE_MIN = '0;
  localparam logic [DATA_W-1:0] CODE_MAX = '1;

  logic [DATA_W-1:0] twosComp;
  logic              railHit;

  assign twosComp = rawCode ^ MSB_MASK;
  assign railHit  = (rawCode == CODE_MIN) || (rawCode == CODE_MAX);

  always_ff @(posedge clk) begin
    if (ctrl.flush) begin
      outValid  <= 1'b0;
      outSample <= '0;
      outSat    <= 1'b0;
    end else begin
      outValid <= ctrl.accept;
      if (ctrl.accept) begin
        outSample <= twosComp;
        outSat    <= railHit;
      end
    end
  end

  // ovfClear is used by the overflow tracker in the top
  logic unusedClr;
  assign unusedClr = ovfClear & outReady & 1'b0;

endmodule

// File: rtl/adc_seq_ovf.sv
module adc_seq_ovf (
  input  logic clk,
  input  logic rst,
  input  logic outValid,
  input  logic outReady,
  input  logic ovfClear,
  output logic ovfFlag
);

  logic lostNow;
  assign lostNow = outValid && !outReady;

  always_ff @(posedge clk) begin
    if (rst)          ovfFlag <= 1'b0;
    else if (lostNow) ovfFlag <= 1'b1;
    else if (ovfClear) ovfFlag <= 1'b0;
  end

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 15,
  parameter int PIPE_LAT   = 4,
  parameter int ENTER_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic [DATA_W-1:0] rawCode,
  output logic              pwrDown,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample,
  output logic              outSat,
  output logic              ovfFlag,
  input  logic              ovfClear
);

  seq_ctrl_t  ctrl;
  seq_state_e seqState;

  adc_seq_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .PIPE_LAT  (PIPE_LAT),
    .ENTER_CYC (ENTER_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sleepReq(sleepReq),
    .wakeReq (wakeReq),
    .pwrDown (pwrDown),
    .ctrl    (ctrl),
    .seqState(seqState)
  );

  adc_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .rawCode  (rawCode),
    .outReady (outReady),
    .ovfClear (ovfClear),
    .outValid (outValid),
    .outSample(outSample),
    .outSat   (outSat)
  );

  adc_seq_ovf u_ovf (
    .clk     (clk),
    .rst     (rst),
    .outValid(outValid),
    .outReady(outReady),
    .ovfClear(ovfClear),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/adc_capture_seq_chk.sv
module adc_capture_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sleepReq,
  input logic              wakeReq,
  input logic              outReady,
  input logic              ovfClear,
  input logic              pwrDown,
  input logic              outValid,
  input logic [DATA_W-1:0] outSample,
  input logic              outSat,
  input logic              ovfFlag,
  input seq_state_e        seqState
);

  localparam logic [DATA_W-1:0] FROM_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] FROM_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pwrDown && !outValid && !ovfFlag));

  // R4
  assert_sat_rails_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSat == ((outSample == FROM_MIN) || (outSample == FROM_MAX))));

  // R5
  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (sleepReq && !pwrDown) |=> (pwrDown && !outValid));

  // R6
  assert_no_valid_asleep_R6: assert property (@(posedge clk) disable iff (rst)
    pwrDown |-> !outValid);

  // R7
  assert_wake_release_R7: assert property (@(posedge clk) disable iff (rst)
    (seqState == SEQ_ASLEEP && wakeReq) |=> !pwrDown);

  // R8
  assert_wake_ignored_entering_R8: assert property (@(posedge clk) disable iff (rst)
    (seqState == SEQ_ENTER) |=> pwrDown);

  // R9
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> ovfFlag);

  // R9
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !ovfClear) |=> ovfFlag);

endmodule

bind adc_capture_seq adc_capture_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sleepReq (sleepReq),
  .wakeReq  (wakeReq),
  .outReady (outReady),
  .ovfClear (ovfClear),
  .pwrDown  (pwrDown),
  .outValid (outValid),
  .outSample(outSample),
  .outSat   (outSat),
  .ovfFlag  (ovfFlag),
  .seqState (seqState)
);

// File: tb/adc_capture_seq_tb.sv
module adc_capture_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleepReq = 1'b0;
  logic       wakeReq = 1'b0;
  logic [7:0] rawCode = 8'h00;
  logic       outReady = 1'b1;
  logic       ovfClear = 1'b0;
  logic       pwrDown, outValid, outSat, ovfFlag;
  logic [7:0] outSample;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_capture_seq u_dut (
    .clk(clk), .rst(rst), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .rawCode(rawCode), .pwrDown(pwrDown), .outReady(outReady),
    .outValid(outValid), .outSample(outSample), .outSat(outSat),
    .ovfFlag(ovfFlag), .ovfClear(ovfClear)
  );

  // raw, expected two's complement, expected saturation
  localparam logic [16:0] VEC [8] = '{
    {8'h00, 8'h80, 1'b1},
    {8'hFF, 8'h7F, 1'b1},
    {8'h80, 8'h00, 1'b0},
    {8'h7F, 8'hFF, 1'b0},
    {8'h01, 8'h81, 1'b0},
    {8'hFE, 8'h7E, 1'b0},
    {8'h55, 8'hD5, 1'b0},
    {8'hC3, 8'h43, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // after a wake or reset edge: 19 edges low, valid after the 20th
  task automatic checkSettle(input string tag);
    for (int i = 0; i < 19; i++) begin
      tick();
      chk(outValid == 1'b0, tag, outValid, 0);
    end
    tick();
    chk(outValid == 1'b1, tag, outValid, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rawCode = 8'h3C;
    repeat (3) tick();
    chk(pwrDown == 1'b0, "R1 pwrDown", pwrDown, 0);
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    chk(ovfFlag == 1'b0, "R1 ovfFlag", ovfFlag, 0);
    rst = 1'b0;
    checkSettle("R2 reset settle");

    // R3 R4: vector walk
    for (int i = 0; i < 8; i++) begin
      rawCode = VEC[i][16:9];
      tick();
      chk(outValid == 1'b1, "R3 valid", outValid, 1);
      chk(outSample == VEC[i][8:1], "R3 sample", outSample, VEC[i][8:1]);
      chk(outSat == VEC[i][0], "R4 sat", outSat, VEC[i][0]);
    end

    // R9: lost sample, sticky, clear, set priority
    outReady = 1'b0;
    tick();
    chk(ovfFlag == 1'b1, "R9 set", ovfFlag, 1);
    outReady = 1'b1;
    repeat (3) tick();
    chk(ovfFlag == 1'b1, "R9 sticky", ovfFlag, 1);
    ovfClear = 1'b1;
    tick();
    ovfClear = 1'b0;
    chk(ovfFlag == 1'b0, "R9 clear", ovfFlag, 0);
    outReady = 1'b0;
    ovfClear = 1'b1;
    tick();
    outReady = 1'b1;
    ovfClear = 1'b0;
    chk(ovfFlag == 1'b1, "R9 set over clear", ovfFlag, 1);
    ovfClear = 1'b1;
    tick();
    ovfClear = 1'b0;

    // R8: wake while active has no effect
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    chk(outValid == 1'b1 && pwrDown == 1'b0, "R8 wake active", {pwrDown, outValid}, 1);

    // R5: sleep entry
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk(pwrDown == 1'b1, "R5 pwrDown", pwrDown, 1);
    chk(outValid == 1'b0, "R5 outValid", outValid, 0);

    // R8 R6: wake during entry ignored, stays asleep whatever raw does
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    for (int i = 0; i < 10; i++) begin
      rawCode = 8'(i * 37);
      if (i == 4) sleepReq = 1'b1;
      tick();
      sleepReq = 1'b0;
      chk(pwrDown == 1'b1 && outValid == 1'b0, "R6 R8 asleep", {pwrDown, outValid}, 2);
    end

    // R7: wake
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    chk(pwrDown == 1'b0, "R7 release", pwrDown, 0);
    checkSettle("R7 wake settle");
    rawCode = 8'h7F;
    tick();
    chk(outSample == 8'hFF, "R7 R3 after wake", outSample, 8'hFF);

    // R10: sleep during settling
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    repeat (4) tick();
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    repeat (5) tick();
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk(pwrDown == 1'b1, "R10 abort settle", pwrDown, 1);
    repeat (4) tick();
    chk(outValid == 1'b0, "R10 no valid", outValid, 0);
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    checkSettle("R10 recover");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule